// File: doc/BRIEF.md
# System Register Access Permission Checker

This block judges one system-register access request per cycle against the current exception level and a set of control inputs. It recognises two register names that differ only in their op1 encoding field: a lower-level name and a hypervisor-level name. For each recognised request it decides one of five outcomes:

- the access completes against one of the two physical registers;
- the access is undefined;
- the access traps to the hypervisor level with syndrome class 0x18;
- the access traps to the highest level with syndrome class 0x18;
- the access is redirected to a fixed memory offset, for nested virtualization.

The outcome is a registered record that appears exactly one cycle after the request. The block does not raise the exception or perform the memory access. It only reports what the pipeline must do.

Top module: `sysreg_gate`

## Requirements
- R1: A recognised request from level 0 (`cur_el`=0), to either name, yields code UNDEF (1). Outcome codes are DONE=0, UNDEF=1, TRAP_HYP=2, TRAP_TOP=3, MEMREDIR=4.
- R2: At level 1, a request to the hypervisor name yields TRAP_HYP when `nested_ctl[0]` is 1. Otherwise it yields UNDEF.
- R3: At level 2, both names are gated when `el3_present`=1 and `el3_acc_en`=0. Under that gate the outcome is UNDEF if `el3_undef_first`=1, else UNDEF if `el3_undef_late`=1, else TRAP_TOP.
- R4: At level 3, both names always yield DONE. `out_hyp_sel` is 1 for the hypervisor name and 0 for the lower name.
- R5: At level 1, a request to the lower name takes the first check that fires, in this order:
  - `el3_present && !el3_acc_en && el3_undef_first` gives UNDEF;
  - with `el2_enabled`, the virtual-memory trap bit (`vm_trap_wr` for writes, `vm_trap_rd` for reads) gives TRAP_HYP;
  - with `el2_enabled`, the fine-grained trap bit (see R6) gives TRAP_HYP;
  - with `el2_enabled`, `!(xctl_present && xctl_acc_en)` gives TRAP_HYP;
  - `el3_present && !el3_acc_en` gives UNDEF if `el3_undef_late`, else TRAP_TOP.
- R6: The fine-grained bit counts only when `fgt_impl`=1 and either `el3_present`=0 or `el3_fgt_en`=1. Writes use `fgt_trap_wr` and reads use `fgt_trap_rd`.
- R7: When no R5 check fires and `nested_ctl`=3'b111, the outcome is MEMREDIR with `out_mem_off`=0x278. Otherwise a lower-name access at level 1 yields DONE with `out_hyp_sel`=0.
- R8: At level 2 with the gate of R3 clear, the hypervisor name yields DONE with `out_hyp_sel`=1. The lower name yields DONE with `out_hyp_sel` equal to `host_mode`.
- R9: A request is recognised only for op0=3, CRn=1, CRm=0 and op2=3, with op1=4 (hypervisor name) or op1=0 (lower name). Any other encoding, or `req_valid`=0, gives `out_valid`=0 on the next cycle.
- R10: The record appears exactly one cycle after the request and reset clears `out_valid`. In a valid record:
  - `out_target_el` is 2 for TRAP_HYP, 3 for TRAP_TOP and 0 otherwise;
  - `out_ec` is 0x18 for traps and 0 otherwise;
  - `out_mem_off` is 0 unless the outcome is MEMREDIR;
  - `out_hyp_sel` is 0 unless the outcome is DONE.
  
  All fields are 0 when `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_op0 | input | 2 | Encoding op0 |
| req_op1 | input | 3 | Encoding op1 |
| req_crn | input | 4 | Encoding CRn |
| req_crm | input | 4 | Encoding CRm |
| req_op2 | input | 3 | Encoding op2 |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | Hypervisor level enabled |
| el3_present | input | 1 | Highest level implemented |
| el3_acc_en | input | 1 | Highest level's enable for this register |
| el3_undef_first | input | 1 | Priority undefined condition |
| el3_undef_late | input | 1 | Secondary undefined condition |
| nested_ctl | input | 3 | Nested-virtualization bits |
| vm_trap_rd | input | 1 | Virtual-memory read trap bit |
| vm_trap_wr | input | 1 | Virtual-memory write trap bit |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| el3_fgt_en | input | 1 | Highest level's fine-grained enable |
| fgt_trap_rd | input | 1 | Fine-grained read trap bit |
| fgt_trap_wr | input | 1 | Fine-grained write trap bit |
| xctl_present | input | 1 | Extended hypervisor control available |
| xctl_acc_en | input | 1 | Extended control's enable for this register |
| host_mode | input | 1 | Hypervisor runs in host mode |
| out_valid | output | 1 | Outcome record valid |
| out_code | output | 3 | Outcome code |
| out_target_el | output | 2 | Trap target level |
| out_ec | output | 6 | Syndrome class |
| out_mem_off | output | 12 | Redirect memory offset |
| out_hyp_sel | output | 1 | 1 selects the hypervisor register |

## Verification
The outcome record is recomputed every cycle from the current request, and the block holds no other state. A wrong decision therefore shows up on the ports exactly one cycle after the offending request and never persists beyond that record.

An ordering fault in the level-1 check chain only appears when two or more checks fire at once. The random stimulus sets many control bits together so that every pair of adjacent checks competes. Field-zeroing faults appear as nonzero target, syndrome, offset or select in records that should not carry them.

// File: rtl/sysreg_gate.sv
module sysreg_gate #(
  parameter int EC_W  = 6,
  parameter int OFF_W = 12,
  parameter logic [EC_W-1:0]  TRAP_EC = 6'h18,
  parameter logic [OFF_W-1:0] NV_OFF  = 12'h278
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_op0,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [1:0]       cur_el,
  input  logic             el2_enabled,
  input  logic             el3_present,
  input  logic             el3_acc_en,
  input  logic             el3_undef_first,
  input  logic             el3_undef_late,
  input  logic [2:0]       nested_ctl,
  input  logic             vm_trap_rd,
  input  logic             vm_trap_wr,
  input  logic             fgt_impl,
  input  logic             el3_fgt_en,
  input  logic             fgt_trap_rd,
  input  logic             fgt_trap_wr,
  input  logic             xctl_present,
  input  logic             xctl_acc_en,
  input  logic             host_mode,
  output logic             out_valid,
  output logic [2:0]       out_code,
  output logic [1:0]       out_target_el,
  output logic [EC_W-1:0]  out_ec,
  output logic [OFF_W-1:0] out_mem_off,
  output logic             out_hyp_sel
);
  localparam logic [2:0] C_DONE = 3'd0, C_UNDEF = 3'd1, C_THYP = 3'd2,
                         C_TTOP = 3'd3, C_MEM = 3'd4;

  wire common  = req_op0 == 2'd3 && req_crn == 4'd1 && req_crm == 4'd0 && req_op2 == 3'd3;
  wire hit_hyp = common && req_op1 == 3'd4;
  wire hit_low = common && req_op1 == 3'd0;
  wire take    = req_valid && (hit_hyp || hit_low);

  wire el3_gate  = el3_present && !el3_acc_en;
  wire [2:0] gate_res = el3_undef_first ? C_UNDEF : (el3_undef_late ? C_UNDEF : C_TTOP);
  wire vm_bit    = req_write ? vm_trap_wr : vm_trap_rd;
  wire fgt_ok    = fgt_impl && (!el3_present || el3_fgt_en);
  wire fgt_bit   = req_write ? fgt_trap_wr : fgt_trap_rd;
  wire xctl_off  = !(xctl_present && xctl_acc_en);

  logic [2:0] nxt_code;
  logic       nxt_sel;

  always_comb begin
    nxt_code = C_DONE;
    nxt_sel  = 1'b0;
    unique case (cur_el)
      2'd0: nxt_code = C_UNDEF;
      2'd1: begin
        if (hit_hyp)                            nxt_code = nested_ctl[0] ? C_THYP : C_UNDEF;
        else if (el3_gate && el3_undef_first)   nxt_code = C_UNDEF;
        else if (el2_enabled && vm_bit)         nxt_code = C_THYP;
        else if (el2_enabled && fgt_ok && fgt_bit) nxt_code = C_THYP;
        else if (el2_enabled && xctl_off)       nxt_code = C_THYP;
        else if (el3_gate)                      nxt_code = el3_undef_late ? C_UNDEF : C_TTOP;
        else if (nested_ctl == 3'b111)          nxt_code = C_MEM;
      end
      2'd2: begin
        if (el3_gate) nxt_code = gate_res;
        else          nxt_sel  = hit_hyp || host_mode;
      end
      default: nxt_sel = hit_hyp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !take) begin
      out_valid     <= 1'b0;
      out_code      <= C_DONE;
      out_target_el <= 2'd0;
      out_ec        <= '0;
      out_mem_off   <= '0;
      out_hyp_sel   <= 1'b0;
    end else begin
      out_valid     <= 1'b1;
      out_code      <= nxt_code;
      out_target_el <= (nxt_code == C_THYP) ? 2'd2 : (nxt_code == C_TTOP) ? 2'd3 : 2'd0;
      out_ec        <= (nxt_code == C_THYP || nxt_code == C_TTOP) ? TRAP_EC : '0;
      out_mem_off   <= (nxt_code == C_MEM) ? NV_OFF : '0;
      out_hyp_sel   <= (nxt_code == C_DONE) ? nxt_sel : 1'b0;
    end
  end

  a_r1_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_el == 2'd0 |=> out_valid && out_code == C_UNDEF);
  a_r4_el3_done: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_el == 2'd3 |=> out_valid && out_code == C_DONE && out_hyp_sel == $past(hit_hyp));
  a_r2_hyp_nested: assert property (@(posedge clk) disable iff (!rst_n)
    take && hit_hyp && cur_el == 2'd1 && nested_ctl[0] |=> out_code == C_THYP && out_ec == TRAP_EC);
  a_r3_top_trap: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_el == 2'd2 && el3_gate && !el3_undef_first && !el3_undef_late
    |=> out_code == C_TTOP && out_target_el == 2'd3);
  a_r9_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !out_valid);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_code == 3'd0 && out_ec == '0 && out_mem_off == '0 && !out_hyp_sel);
  a_r7_mem_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == C_MEM |-> out_mem_off == NV_OFF && out_target_el == 2'd0);
endmodule

// File: tb/sysreg_gate_bench.sv
module sysreg_gate_bench;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [1:0] req_op0 = 0; logic [2:0] req_op1 = 0;
  logic [3:0] req_crn = 0, req_crm = 0; logic [2:0] req_op2 = 0;
  logic [1:0] cur_el = 0;
  logic el2_enabled = 0, el3_present = 0, el3_acc_en = 0, el3_undef_first = 0, el3_undef_late = 0;
  logic [2:0] nested_ctl = 0;
  logic vm_trap_rd = 0, vm_trap_wr = 0, fgt_impl = 0, el3_fgt_en = 0, fgt_trap_rd = 0, fgt_trap_wr = 0;
  logic xctl_present = 0, xctl_acc_en = 0, host_mode = 0;
  logic out_valid, out_hyp_sel;
  logic [2:0] out_code; logic [1:0] out_target_el;
  logic [5:0] out_ec; logic [11:0] out_mem_off;

  int tests = 0, fails = 0;

  sysreg_gate u_sysreg_gate (.*);

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog R10 act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // expected record: {valid, code, tel, ec, off, sel}
  function automatic logic [24:0] model();
    logic hy, lo, gate; logic [2:0] c; logic s;
    hy = req_op0 == 3 && req_op1 == 4 && req_crn == 1 && req_crm == 0 && req_op2 == 3;
    lo = req_op0 == 3 && req_op1 == 0 && req_crn == 1 && req_crm == 0 && req_op2 == 3;
    if (!req_valid || !(hy || lo)) return '0;
    gate = el3_present & ~el3_acc_en;
    c = 0; s = 0;
    if (cur_el == 0) c = 1;
    else if (cur_el == 3) s = hy;
    else if (cur_el == 2) begin
      if (gate) c = (el3_undef_first | el3_undef_late) ? 3'd1 : 3'd3;
      else s = hy | host_mode;
    end else if (hy) c = nested_ctl[0] ? 3'd2 : 3'd1;
    else begin
      if (gate & el3_undef_first) c = 1;
      else if (el2_enabled & (req_write ? vm_trap_wr : vm_trap_rd)) c = 2;
      else if (el2_enabled & fgt_impl & (~el3_present | el3_fgt_en) & (req_write ? fgt_trap_wr : fgt_trap_rd)) c = 2;
      else if (el2_enabled & ~(xctl_present & xctl_acc_en)) c = 2;
      else if (gate) c = el3_undef_late ? 3'd1 : 3'd3;
      else if (&nested_ctl) c = 4;
    end
    return {1'b1, c, (c == 2) ? 2'd2 : (c == 3) ? 2'd3 : 2'd0,
            (c == 2 || c == 3) ? 6'h18 : 6'h0, (c == 4) ? 12'h278 : 12'h0,
            (c == 0) ? s : 1'b0};
  endfunction

  task automatic check(string tag);
    logic [24:0] exp, act;
    exp = model();
    @(negedge clk);
    act = {out_valid, out_code, out_target_el, out_ec, out_mem_off, out_hyp_sel};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic enc(input bit hyp);
    req_op0 = 3; req_op1 = hyp ? 3'd4 : 3'd0; req_crn = 1; req_crm = 0; req_op2 = 3;
  endtask

  task automatic clean();
    req_valid = 1; req_write = 0; el2_enabled = 1; el3_present = 1; el3_acc_en = 1;
    el3_undef_first = 0; el3_undef_late = 0; nested_ctl = 0; vm_trap_rd = 0; vm_trap_wr = 0;
    fgt_impl = 1; el3_fgt_en = 1; fgt_trap_rd = 0; fgt_trap_wr = 0;
    xctl_present = 1; xctl_acc_en = 1; host_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 0) begin fails++; $display("FAIL R10 reset act=%b exp=0", out_valid); end
    rst_n = 1;
    clean();
    cur_el = 0; enc(0); check("R1 el0 low");
    enc(1); check("R1 el0 hyp");
    cur_el = 1; nested_ctl = 3'b001; check("R2 el1 hyp nested");
    nested_ctl = 0; check("R2 el1 hyp undef");
    enc(0); check("R7 el1 low done");
    nested_ctl = 3'b111; check("R7 redirect");
    el3_acc_en = 0; check("R5 late trap top");
    el3_undef_late = 1; check("R5 late undef");
    el3_undef_first = 1; vm_trap_rd = 1; check("R5 first undef wins");
    el3_undef_first = 0; check("R5 vm read trap");
    vm_trap_rd = 0; req_write = 1; vm_trap_wr = 0; fgt_trap_wr = 1; check("R6 fgt write");
    el3_fgt_en = 0; check("R6 fgt masked");
    el3_present = 0; check("R6 fgt no top level");
    fgt_trap_wr = 0; xctl_acc_en = 0; check("R5 xctl trap");
    clean(); cur_el = 2; enc(0); host_mode = 1; check("R8 host alias");
    host_mode = 0; check("R8 lower");
    enc(1); check("R8 hyp");
    el3_acc_en = 0; check("R3 trap top");
    el3_undef_late = 1; check("R3 late undef");
    el3_undef_first = 1; check("R3 first undef");
    clean(); cur_el = 3; enc(0); el3_acc_en = 0; check("R4 low");
    enc(1); check("R4 hyp");
    req_op2 = 2; check("R9 bad enc");
    enc(1); req_op1 = 1; check("R9 bad op1");
    enc(1); req_valid = 0; check("R9 no valid");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      req_valid = r[0] | r[1]; req_write = r[2]; cur_el = r[4:3];
      enc(r[5]); if (r[9:6] == 0) req_op1 = r[12:10];
      el2_enabled = r[13] | r[14]; el3_present = r[15]; el3_acc_en = r[16];
      el3_undef_first = r[17] & r[18]; el3_undef_late = r[19]; nested_ctl = {r[20] | r[21], r[22] | r[21], r[23]};
      vm_trap_rd = r[24] & r[25]; vm_trap_wr = r[25] & r[26]; fgt_impl = r[27];
      el3_fgt_en = r[28]; fgt_trap_rd = r[29]; fgt_trap_wr = r[30];
      r = $urandom();
      xctl_present = r[0] | r[1]; xctl_acc_en = r[2] | r[3]; host_mode = r[4];
      check(cur_el == 0 ? "R1 rand" : cur_el == 3 ? "R4 rand" : cur_el == 2 ? "R3 R8 rand" : "R5 R2 rand");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule